// File: doc/BRIEF.md
# Filtered Input Capture Timer

This block is the capture side of a 16-bit timer. A free-running counter advances on every clock and raises an overflow flag when it wraps. Two or more capture channels watch their own input pins. Each channel can react to rising or falling transitions. It can first pass the pin through a digital noise filter that requires a stable level. It can also be told to skip a programmed number of qualifying transitions before it records anything. When a channel fires, it copies the counter into its own capture register and raises its own flag.

Every flag has its own enable. The enabled flags are ORed together, and the result is gated by a unit-wide enable to form a single interrupt line. Software clears a flag by pulsing its clear input, which stands for a write of one. If a new event arrives in the same cycle, the event wins. Inputs are assumed to be synchronous to the clock already.

Top module: `icap_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, every capture register, every flag and `irq` become zero, and the recognised level of each pin becomes low.
- R2: `timer_val` increases by one at every clock edge and wraps from 0xFFFF to 0. `ovf_flag` rises at the same edge where the counter wraps.
- R3: `cfg_fall[i]` = 0 selects rising transitions and 1 selects falling transitions on `cap_in[i]`. A transition in the other direction neither captures nor sets a flag.
- R4: With the filter off, a pin level sampled at edge k that differs from the recognised level is a transition. If the transition qualifies and fires, the capture register holds, from edge k+1, the `timer_val` value present between edges k and k+1.
- R5: With `cfg_filt[i]` = 1, a new level counts only after four consecutive samples show it. The capture then holds the `timer_val` value present after the fourth sampling edge. A level held for fewer than four samples is ignored.
- R6: With `cfg_evt` slice i = N, channel i captures on every (N+1)-th qualifying transition since reset or since its last capture. N = 0 captures on every one.
- R7: A pulse on a clear input drops its flag at the next edge. When a capture or overflow event coincides with the clear, the flag stays set. Flag index i is capture channel i, and index NUM_CH is overflow.
- R8: `irq` is high exactly when `unit_ie` is high and at least one flag is set with its enable (`cap_ie[i]` or `ovf_ie`) high.
- R9: A capture on one channel leaves the other channels' capture registers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | NUM_CH | Capture pins, one per channel |
| cfg_fall | input | NUM_CH | Edge select per channel: 0 rising, 1 falling |
| cfg_filt | input | NUM_CH | Noise filter enable per channel |
| cfg_evt | input | NUM_CH*EVT_W | Events to skip per channel, channel i at bits [i*EVT_W +: EVT_W] |
| cap_ie | input | NUM_CH | Interrupt enable per capture flag |
| ovf_ie | input | 1 | Interrupt enable for the overflow flag |
| unit_ie | input | 1 | Unit-level interrupt gate |
| cap_clr | input | NUM_CH | Clear pulse per capture flag |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| timer_val | output | TMR_W | Free-running counter |
| ovf_flag | output | 1 | Overflow flag |
| cap_val | output | NUM_CH*TMR_W | Capture registers, channel i at bits [i*TMR_W +: TMR_W] |
| cap_flag | output | NUM_CH | Capture flags |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is a capture that fires in the same cycle as a clear of its own flag. The fire comes one cycle after the sampling edge, and that cycle can only be found by counting edges. The bench raises the pin, waits exactly one edge, and only then pulses the clear. A second hard case is reaching the filter's fourth sample exactly. Here the bench holds a pin for three samples to show that it is rejected, then holds it for four and checks the captured value against the counter read one edge after the level changed. The counter wrap needs 65536 cycles, so the bench runs the counter there once after the random phase.

// File: rtl/icap_pkg.sv
// Shared types of the input capture unit.
// Assumes: nothing beyond IEEE 1800-2017.
package icap_pkg;

    // Transition direction a channel reacts to.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/icap_timebase.sv
// Free-running up counter with a one-cycle wrap indication.
// Assumes: counts on every clock; wrap_o is high in the cycle the counter
// holds its all-ones value, so the wrap and the reload to zero share an edge.
module icap_timebase #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] count_o,
    output logic             wrap_o
);

    logic [TMR_W-1:0] count_q;

    // Advance the counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // Flag the last value before the wrap.
    always_comb begin
        wrap_o = (count_q == {TMR_W{1'b1}});
    end

    assign count_o = count_q;

endmodule

// File: rtl/icap_edge_qual.sv
// Pin sampler, optional stability filter and edge detector for one channel.
// Assumes: pin_i is synchronous to clk. The last FILT_DEPTH samples are kept.
// With the filter on, a level is accepted only when all of them agree. With
// it off, the newest sample is accepted. evt_o marks an accepted change in
// the selected direction, combinationally, in the cycle after the sampling edge.
module icap_edge_qual
    import icap_pkg::*;
#(
    parameter int FILT_DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  logic      filt_en_i,
    input  edge_sel_e edge_sel_i,
    output logic      evt_o
);

    logic [FILT_DEPTH-1:0] hist_q;
    logic                  level_q;
    logic                  steady;
    logic                  accept;
    logic                  change;

    // Shift in a new sample and remember the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            level_q <= 1'b0;
        end else begin
            hist_q <= {hist_q[FILT_DEPTH-2:0], pin_i};
            if (change) begin
                level_q <= hist_q[0];
            end
        end
    end

    // Decide whether the newest sample is an accepted transition.
    always_comb begin
        steady = (&hist_q) | ~(|hist_q);
        accept = filt_en_i ? steady : 1'b1;
        change = accept && (hist_q[0] != level_q);
        if (edge_sel_i == EDGE_RISE) begin
            evt_o = change && hist_q[0];
        end else begin
            evt_o = change && !hist_q[0];
        end
    end

endmodule

// File: rtl/icap_evt_div.sv
// Event divider: lets every (limit+1)-th qualifying event through.
// Assumes: limit_i may change at any time. A stored count at or above the
// new limit fires on the next event and restarts from zero.
module icap_evt_div #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [EVT_W-1:0] limit_i,
    output logic             fire_o
);

    logic [EVT_W-1:0] seen_q;

    // Fire when enough events have been skipped.
    always_comb begin
        fire_o = evt_i && (seen_q >= limit_i);
    end

    // Count skipped events and restart after each fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (evt_i) begin
            seen_q <= fire_o ? '0 : seen_q + 1'b1;
        end
    end

endmodule

// File: rtl/icap_flags.sv
// Sticky flag bank with clear-by-pulse and one gated interrupt output.
// Assumes: set_i has priority over clr_i when both are high in one cycle.
module icap_flags #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] clr_i,
    input  logic [N_FLAGS-1:0] ie_i,
    input  logic               unit_ie_i,
    output logic [N_FLAGS-1:0] flag_o,
    output logic               irq_o
);

    logic [N_FLAGS-1:0] flag_q;

    // Set wins, otherwise a clear drops the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= set_i | (flag_q & ~clr_i);
        end
    end

    // Combine the enabled flags into one request.
    always_comb begin
        irq_o = unit_ie_i && (|(flag_q & ie_i));
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/icap_unit.sv
// Input capture unit: free-running counter, NUM_CH filtered capture channels,
// sticky flags and one shared interrupt.
// Assumes: all inputs are synchronous to clk. Clear inputs are one-cycle
// pulses that stand for a software write of one.
module icap_unit
    import icap_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int NUM_CH     = 2,
    parameter int EVT_W      = 4,
    parameter int FILT_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       cap_in,
    input  logic [NUM_CH-1:0]       cfg_fall,
    input  logic [NUM_CH-1:0]       cfg_filt,
    input  logic [NUM_CH*EVT_W-1:0] cfg_evt,
    input  logic [NUM_CH-1:0]       cap_ie,
    input  logic                    ovf_ie,
    input  logic                    unit_ie,
    input  logic [NUM_CH-1:0]       cap_clr,
    input  logic                    ovf_clr,
    output logic [TMR_W-1:0]        timer_val,
    output logic                    ovf_flag,
    output logic [NUM_CH*TMR_W-1:0] cap_val,
    output logic [NUM_CH-1:0]       cap_flag,
    output logic                    irq
);

    localparam int N_FLAGS = NUM_CH + 1;

    logic [TMR_W-1:0]   count;
    logic               wrap;
    logic [NUM_CH-1:0]  qual_evt;
    logic [NUM_CH-1:0]  cap_fire;
    logic [N_FLAGS-1:0] flag_vec;

    icap_timebase #(.TMR_W(TMR_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count),
        .wrap_o  (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [TMR_W-1:0] cap_q;

        icap_edge_qual #(.FILT_DEPTH(FILT_DEPTH)) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (cap_in[ch]),
            .filt_en_i  (cfg_filt[ch]),
            .edge_sel_i (edge_sel_e'(cfg_fall[ch])),
            .evt_o      (qual_evt[ch])
        );

        icap_evt_div #(.EVT_W(EVT_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (qual_evt[ch]),
            .limit_i (cfg_evt[ch*EVT_W +: EVT_W]),
            .fire_o  (cap_fire[ch])
        );

        // Latch the counter value of the firing cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q <= '0;
            end else if (cap_fire[ch]) begin
                cap_q <= count;
            end
        end

        assign cap_val[ch*TMR_W +: TMR_W] = cap_q;
    end

    icap_flags #(.N_FLAGS(N_FLAGS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     ({wrap, cap_fire}),
        .clr_i     ({ovf_clr, cap_clr}),
        .ie_i      ({ovf_ie, cap_ie}),
        .unit_ie_i (unit_ie),
        .flag_o    (flag_vec),
        .irq_o     (irq)
    );

    assign timer_val = count;
    assign ovf_flag  = flag_vec[NUM_CH];
    assign cap_flag  = flag_vec[NUM_CH-1:0];

endmodule

// File: rtl/icap_unit_sva.sv
// Property checker for icap_unit, attached by bind.
// Assumes: cap_fire is the internal per-channel capture strobe of the top.
module icap_unit_sva #(
    parameter int TMR_W  = 16,
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [TMR_W-1:0]        timer_val,
    input logic                    ovf_flag,
    input logic                    ovf_clr,
    input logic [NUM_CH*TMR_W-1:0] cap_val,
    input logic [NUM_CH-1:0]       cap_flag,
    input logic [NUM_CH-1:0]       cap_clr,
    input logic [NUM_CH-1:0]       cap_fire,
    input logic                    unit_ie,
    input logic                    irq
);

    p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (timer_val == $past(timer_val) + 1'b1));

    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_val == {TMR_W{1'b1}}) |=> ovf_flag);

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && timer_val != {TMR_W{1'b1}}) |=> !ovf_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_ie |-> !irq);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        p_cap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cap_fire[ch] |=> (cap_val[ch*TMR_W +: TMR_W] == $past(timer_val)));

        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cap_fire[ch] |=> cap_flag[ch]);

        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_clr[ch] && !cap_fire[ch]) |=> !cap_flag[ch]);

        p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_fire[ch] |=> $stable(cap_val[ch*TMR_W +: TMR_W]));
    end

endmodule

bind icap_unit icap_unit_sva #(.TMR_W(TMR_W), .NUM_CH(NUM_CH)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .cap_val   (cap_val),
    .cap_flag  (cap_flag),
    .cap_clr   (cap_clr),
    .cap_fire  (cap_fire),
    .unit_ie   (unit_ie),
    .irq       (irq)
);

// File: tb/icap_unit_tb_top.sv
module icap_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW   = 16;
    localparam int NCH  = 2;
    localparam int EW   = 4;
    localparam int FD   = 4;
    localparam int SEED = 7321;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    cap_in = '0;
    logic [NCH-1:0]    cfg_fall = '0;
    logic [NCH-1:0]    cfg_filt = '0;
    logic [NCH*EW-1:0] cfg_evt = '0;
    logic [NCH-1:0]    cap_ie = '0;
    logic              ovf_ie = 1'b0;
    logic              unit_ie = 1'b0;
    logic [NCH-1:0]    cap_clr = '0;
    logic              ovf_clr = 1'b0;
    logic [TW-1:0]     timer_val;
    logic              ovf_flag;
    logic [NCH*TW-1:0] cap_val;
    logic [NCH-1:0]    cap_flag;
    logic              irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // reference state
    logic [TW-1:0] m_t;
    logic [FD-1:0] m_h [NCH];
    logic          m_lvl [NCH];
    logic [EW-1:0] m_c [NCH];
    logic [TW-1:0] m_cap [NCH];
    logic [NCH-1:0] m_cf;
    logic          m_of;

    always #(CLK_PERIOD/2) clk = ~clk;

    icap_unit #(.TMR_W(TW), .NUM_CH(NCH), .EVT_W(EW), .FILT_DEPTH(FD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cfg_fall(cfg_fall),
        .cfg_filt(cfg_filt), .cfg_evt(cfg_evt), .cap_ie(cap_ie),
        .ovf_ie(ovf_ie), .unit_ie(unit_ie), .cap_clr(cap_clr),
        .ovf_clr(ovf_clr), .timer_val(timer_val), .ovf_flag(ovf_flag),
        .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [TW-1:0] capv(input int ch);
        return cap_val[ch*TW +: TW];
    endfunction

    function automatic logic exp_irq();
        return unit_ie && ((|(m_cf & cap_ie)) || (m_of && ovf_ie));
    endfunction

    // Advance the reference by one edge using the inputs held across it.
    task automatic model_step();
        if (!rst_n) begin
            m_t = '0; m_cf = '0; m_of = 1'b0;
            for (int ch = 0; ch < NCH; ch++) begin
                m_h[ch] = '0; m_lvl[ch] = 1'b0; m_c[ch] = '0; m_cap[ch] = '0;
            end
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                logic uni, ok, nl, ev, ql, fr;
                uni = (m_h[ch] == '1) || (m_h[ch] == '0);
                ok  = cfg_filt[ch] ? uni : 1'b1;
                nl  = m_h[ch][0];
                ev  = ok && (nl != m_lvl[ch]);
                ql  = ev && (cfg_fall[ch] ? !nl : nl);
                fr  = ql && (m_c[ch] >= cfg_evt[ch*EW +: EW]);
                if (ev) m_lvl[ch] = nl;
                if (ql) m_c[ch] = fr ? '0 : m_c[ch] + 1'b1;
                if (fr) m_cap[ch] = m_t;
                m_cf[ch] = fr | (m_cf[ch] & !cap_clr[ch]);
                m_h[ch] = {m_h[ch][FD-2:0], cap_in[ch]};
            end
            m_of = (m_t == '1) | (m_of & !ovf_clr);
            m_t  = m_t + 1'b1;
        end
    endtask

    task automatic compare_all();
        chk("R2 timer", timer_val, m_t);
        chk("R2 overflow flag", ovf_flag, m_of);
        for (int ch = 0; ch < NCH; ch++) begin
            chk("R4 capture value", capv(ch), m_cap[ch]);
        end
        chk("R7 capture flags", cap_flag, m_cf);
        chk("R8 irq", irq, exp_irq());
    endtask

    // One clock: edge, reference update, compare, return at the falling edge.
    task automatic step();
        @(posedge clk);
        #1;
        model_step();
        compare_all();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : watchdog
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [TW-1:0] t0;
        logic [TW-1:0] other;
        int unused_seed;
        unused_seed = $urandom(SEED);
        unit_ie = 1'b1; cap_ie = '1; ovf_ie = 1'b1;
        @(negedge clk);
        steps(3);
        // R1 reset state
        chk("R1 timer in reset", timer_val, 0);
        chk("R1 captures in reset", cap_val, 0);
        chk("R1 flags in reset", {ovf_flag, cap_flag}, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        steps(2);

        // R4 unfiltered rising capture, R9 isolation
        other = capv(1);
        cap_in[0] = 1'b1;
        step();
        t0 = timer_val;
        step();
        chk("R4 capture equals counter after sampling edge", capv(0), t0);
        chk("R4 flag set", cap_flag[0], 1);
        chk("R9 other capture untouched", capv(1), other);
        chk("R9 other flag untouched", cap_flag[1], 0);

        // R7 clear, R3 wrong direction ignored
        cap_clr[0] = 1'b1; step(); cap_clr[0] = 1'b0;
        chk("R7 clear drops flag", cap_flag[0], 0);
        cap_in[0] = 1'b0; steps(3);
        chk("R3 falling ignored when rising selected", cap_flag[0], 0);
        chk("R3 capture held", capv(0), t0);
        cfg_fall[0] = 1'b1;
        cap_in[0] = 1'b1; steps(3);
        chk("R3 rising ignored when falling selected", cap_flag[0], 0);
        cap_in[0] = 1'b0;
        step();
        t0 = timer_val;
        step();
        chk("R3 falling captured", capv(0), t0);
        cfg_fall[0] = 1'b0;
        cap_clr[0] = 1'b1; step(); cap_clr[0] = 1'b0;

        // R5 filter: short pulse rejected, held level accepted
        cfg_filt[1] = 1'b1;
        other = capv(1);
        cap_in[1] = 1'b1; steps(3);
        cap_in[1] = 1'b0; steps(6);
        chk("R5 three-sample pulse ignored", cap_flag[1], 0);
        chk("R5 capture unchanged", capv(1), other);
        cap_in[1] = 1'b1;
        step();
        t0 = timer_val;
        steps(3);
        chk("R5 no capture before fourth sample", cap_flag[1], 0);
        step();
        chk("R5 filtered capture value", capv(1), t0 + 16'd3);
        chk("R5 filtered flag", cap_flag[1], 1);

        // R6 event divider: N=2 fires on the third edge
        cfg_evt[0 +: EW] = 4'd2;
        for (int p = 0; p < 3; p++) begin
            cap_in[0] = 1'b1; steps(2);
            cap_in[0] = 1'b0; steps(2);
            chk("R6 divided capture", cap_flag[0], (p == 2) ? 1 : 0);
        end
        cfg_evt[0 +: EW] = '0;

        // R7 set wins over a clear in the same cycle
        cap_in[0] = 1'b1;
        step();
        cap_clr[0] = 1'b1;
        step();
        cap_clr[0] = 1'b0;
        chk("R7 set wins over clear", cap_flag[0], 1);
        cap_in[0] = 1'b0; step();

        // R8 interrupt gating
        unit_ie = 1'b0; #1;
        chk("R8 unit gate off", irq, 0);
        unit_ie = 1'b1; #1;
        chk("R8 enabled flag drives irq", irq, 1);
        cap_ie = '0; ovf_ie = 1'b0; #1;
        chk("R8 all enables off", irq, 0);
        step();

        // random phase
        for (int c = 0; c < 20000; c++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if ($urandom % 8 == 0) cap_in[ch] = ~cap_in[ch];
                cap_clr[ch] = ($urandom % 16 == 0);
                if ($urandom % 200 == 0) begin
                    cfg_fall[ch] = $urandom % 2;
                    cfg_filt[ch] = $urandom % 2;
                    cfg_evt[ch*EW +: EW] = EW'($urandom % 4);
                end
            end
            ovf_clr = ($urandom % 16 == 0);
            if ($urandom % 50 == 0) begin
                cap_ie = NCH'($urandom); ovf_ie = $urandom % 2; unit_ie = $urandom % 2;
            end
            step();
        end
        cap_clr = '0; ovf_clr = 1'b0;

        // R2 wrap
        while (timer_val != 16'hFFFF) step();
        step();
        chk("R2 wrap to zero", timer_val, 0);
        chk("R2 overflow flag at wrap", ovf_flag, 1);

        // R1 reset mid-run
        unit_ie = 1'b1; cap_ie = '1; ovf_ie = 1'b1;
        rst_n = 1'b0; step();
        chk("R1 timer after reset", timer_val, 0);
        chk("R1 flags after reset", {ovf_flag, cap_flag}, 0);
        chk("R1 captures after reset", cap_val, 0);
        chk("R1 irq after reset", irq, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule